// File: doc/BRIEF.md
# Gradient-Division Line Rasterizer

The block draws straight lines into a pixel stream. A command gives a colour and a signed displacement (dx, dy) from a stored pen origin. The block then sends one pixel coordinate per accepted handshake on its output port. Each pixel carries the command's colour. When the last pixel has been taken, the pen origin moves to the line's end point, so a sequence of commands traces a connected polyline. The origin is (0, 0) after reset.

The block does not track a running error term. It divides once per line to form a fixed-point gradient no larger than one, using a sequential divider that produces one quotient bit per cycle. For each step along the major axis it forms the minor-axis offset as the high half of gradient × step. It handles the four quadrants in two ways. When the minor displacement is negative, it starts from the far end of the line. When the two displacements differ in sign, it complements the step counter. The result is that only non-negative minor offsets are ever added.

Top module: `div_line_raster`

## Requirements
- R1: The x axis is the major axis when |dx| > |dy|, compared as unsigned magnitudes. Otherwise y is the major axis, including when |dx| = |dy|. The other axis is the minor axis.
- R2: The gradient is floor(|minor| × 65536 / |major|) as an unsigned 16-bit value. When |minor| = |major|, the true quotient would be 65536, and the gradient saturates to 0xFFFF instead.
- R3: For step i, the minor-axis offset is bits 31:16 of the 32-bit product gradient × i.
- R4: For step i, the major-axis offset is i XOR 0xFFFF when the sign bits (bit 15) of dx and dy differ, and i otherwise. A zero displacement counts as non-negative.
- R5: When the minor displacement is negative, the base point is origin + (dx, dy). Otherwise the base point is the origin. Each pixel is the base point plus the major and minor offsets, each placed on its own axis.
- R6: A non-zero command produces exactly |major| pixels, for i = 0 … |major|−1 in increasing order. Each pixel carries the command's colour, and pix_valid_o is never high while the block is idle.
- R7: When the handshake of the last pixel completes, the origin becomes the previous origin + (dx, dy). The origin does not change at any other time during a line.
- R8: A command with dx = dy = 0 is accepted but emits no pixel. It leaves the origin unchanged and does not raise busy_o.
- R9: cmd_ready_o is high only when the block is idle. busy_o goes high in the cycle after a non-zero command is accepted and stays high until the last pixel handshake.
- R10: While pix_valid_o is high and pix_ready_i is low, pix_valid_o, the coordinates and the colour stay unchanged into the next cycle.
- R11: All coordinate and origin arithmetic wraps modulo 2^16.
- R12: After reset the origin is (0, 0), busy_o and pix_valid_o are low, and cmd_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command can be accepted (idle) |
| cmd_colour_i | input | CW | Colour for the line |
| cmd_dx_i | input | W | Signed x displacement |
| cmd_dy_i | input | W | Signed y displacement |
| pix_valid_o | output | 1 | Pixel available |
| pix_ready_i | input | 1 | Pixel consumer ready |
| pix_x_o | output | W | Pixel x coordinate |
| pix_y_o | output | W | Pixel y coordinate |
| pix_colour_o | output | CW | Pixel colour |
| busy_o | output | 1 | Line in progress |
| org_x_o | output | W | Current origin x |
| org_y_o | output | W | Current origin y |

## Verification
The assertions check the protocol rules on every cycle. These are the stall-hold of the pixel port, the link between valid and busy, a constant colour during a line, an origin that holds during a line and through zero commands, and busy rising after a non-zero command. Only the bench's scenarios can show the geometry. That covers the axis selection, the saturated gradient, the complemented major counter, the base shift for a negative minor axis, the exact pixel sequence and count, and wrap-around of the coordinates. The bench checks these by sweeping every displacement in a small square and adding long lines that cross the coordinate boundary.

// File: rtl/dlr_pkg.sv
package dlr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIV,
    ST_DRAW
  } dlr_state_e;
endpackage

// File: rtl/dlr_setup.sv
module dlr_setup #(
  parameter int W = 16
) (
  input  logic [W-1:0] dx_i,
  input  logic [W-1:0] dy_i,
  input  logic [W-1:0] org_x_i,
  input  logic [W-1:0] org_y_i,
  output logic         major_x_o,
  output logic         opp_o,
  output logic         zero_o,
  output logic [W-1:0] maj_len_o,
  output logic [W-1:0] mnr_len_o,
  output logic [W-1:0] base_x_o,
  output logic [W-1:0] base_y_o,
  output logic [W-1:0] end_x_o,
  output logic [W-1:0] end_y_o
);
  logic [1:0][W-1:0] disp;
  logic [1:0][W-1:0] mag;
  logic [1:0]        neg;
  logic              min_neg;

  assign disp[0] = dx_i;
  assign disp[1] = dy_i;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    assign neg[a] = disp[a][W-1];
    assign mag[a] = neg[a] ? ({W{1'b0}} - disp[a]) : disp[a];
  end

  assign major_x_o = mag[0] > mag[1];
  assign maj_len_o = major_x_o ? mag[0] : mag[1];
  assign mnr_len_o = major_x_o ? mag[1] : mag[0];
  assign min_neg   = major_x_o ? neg[1] : neg[0];
  assign opp_o     = neg[0] ^ neg[1];
  assign zero_o    = (dx_i == '0) && (dy_i == '0);
  assign end_x_o   = org_x_i + dx_i;
  assign end_y_o   = org_y_i + dy_i;
  // negative minor: start from the far end so minor offsets stay positive
  assign base_x_o  = min_neg ? end_x_o : org_x_i;
  assign base_y_o  = min_neg ? end_y_o : org_y_i;
endmodule

// File: rtl/dlr_div.sv
module dlr_div #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] num_i,   // dividend is num_i * 2^W
  input  logic [W-1:0] den_i,
  output logic [W-1:0] quot_o,
  output logic         done_o
);
  localparam int CNT_W = (W > 2) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     rem_q;
  logic [W-1:0]     den_q;
  logic [W-1:0]     quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             done_q;
  logic [W:0]       rem_sh;
  logic             fits;

  assign rem_sh = {rem_q, 1'b0};
  assign fits   = rem_sh >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        den_q <= den_i;
        cnt_q <= '0;
        if (num_i >= den_i) begin
          quo_q  <= '1;           // quotient would not fit: saturate
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          rem_q <= num_i;
          quo_q <= '0;
          run_q <= 1'b1;
        end
      end else if (run_q) begin
        rem_q <= fits ? W'(rem_sh - {1'b0, den_q}) : W'(rem_sh);
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign quot_o = quo_q;
  assign done_o = done_q;
endmodule

// File: rtl/dlr_step.sv
module dlr_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] grad_i,
  input  logic [W-1:0] idx_i,
  input  logic         opp_i,
  output logic [W-1:0] maj_off_o,
  output logic [W-1:0] min_off_o
);
  logic [2*W-1:0] prod;

  assign prod      = {{W{1'b0}}, grad_i} * {{W{1'b0}}, idx_i};
  assign min_off_o = W'(prod >> W);
  assign maj_off_o = opp_i ? ~idx_i : idx_i;
endmodule

// File: rtl/div_line_raster.sv
module div_line_raster
  import dlr_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [CW-1:0] cmd_colour_i,
  input  logic [W-1:0]  cmd_dx_i,
  input  logic [W-1:0]  cmd_dy_i,
  output logic          pix_valid_o,
  input  logic          pix_ready_i,
  output logic [W-1:0]  pix_x_o,
  output logic [W-1:0]  pix_y_o,
  output logic [CW-1:0] pix_colour_o,
  output logic          busy_o,
  output logic [W-1:0]  org_x_o,
  output logic [W-1:0]  org_y_o
);
  dlr_state_e state_q;

  logic [W-1:0]  org_x_q, org_y_q;
  logic [W-1:0]  base_x_q, base_y_q;
  logic [W-1:0]  end_x_q, end_y_q;
  logic [W-1:0]  len_q, grad_q, idx_q;
  logic [CW-1:0] col_q;
  logic          majx_q, opp_q;

  logic          s_majx, s_opp, s_zero;
  logic [W-1:0]  s_maj, s_mnr, s_bx, s_by, s_ex, s_ey;
  logic [W-1:0]  div_q;
  logic          div_done;
  logic [W-1:0]  maj_off, min_off;
  logic          accept, start, fire, last;

  dlr_setup #(.W(W)) u_setup (
    .dx_i      (cmd_dx_i),
    .dy_i      (cmd_dy_i),
    .org_x_i   (org_x_q),
    .org_y_i   (org_y_q),
    .major_x_o (s_majx),
    .opp_o     (s_opp),
    .zero_o    (s_zero),
    .maj_len_o (s_maj),
    .mnr_len_o (s_mnr),
    .base_x_o  (s_bx),
    .base_y_o  (s_by),
    .end_x_o   (s_ex),
    .end_y_o   (s_ey)
  );

  assign accept = cmd_valid_i && cmd_ready_o;
  assign start  = accept && !s_zero;

  dlr_div #(.W(W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .num_i   (s_mnr),
    .den_i   (s_maj),
    .quot_o  (div_q),
    .done_o  (div_done)
  );

  dlr_step #(.W(W)) u_step (
    .grad_i    (grad_q),
    .idx_i     (idx_q),
    .opp_i     (opp_q),
    .maj_off_o (maj_off),
    .min_off_o (min_off)
  );

  assign fire = pix_valid_o && pix_ready_i;
  assign last = idx_q == (len_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      org_x_q  <= '0;
      org_y_q  <= '0;
      base_x_q <= '0;
      base_y_q <= '0;
      end_x_q  <= '0;
      end_y_q  <= '0;
      len_q    <= '0;
      grad_q   <= '0;
      idx_q    <= '0;
      col_q    <= '0;
      majx_q   <= 1'b0;
      opp_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            base_x_q <= s_bx;
            base_y_q <= s_by;
            end_x_q  <= s_ex;
            end_y_q  <= s_ey;
            len_q    <= s_maj;
            col_q    <= cmd_colour_i;
            majx_q   <= s_majx;
            opp_q    <= s_opp;
            state_q  <= ST_DIV;
          end
        end
        ST_DIV: begin
          if (div_done) begin
            grad_q  <= div_q;
            idx_q   <= '0;
            state_q <= ST_DRAW;
          end
        end
        ST_DRAW: begin
          if (fire) begin
            if (last) begin
              org_x_q <= end_x_q;
              org_y_q <= end_y_q;
              state_q <= ST_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready_o  = state_q == ST_IDLE;
  assign busy_o       = state_q != ST_IDLE;
  assign pix_valid_o  = state_q == ST_DRAW;
  assign pix_x_o      = base_x_q + (majx_q ? maj_off : min_off);
  assign pix_y_o      = base_y_q + (majx_q ? min_off : maj_off);
  assign pix_colour_o = col_q;
  assign org_x_o      = org_x_q;
  assign org_y_o      = org_y_q;
endmodule

// File: rtl/dlr_checker.sv
module dlr_checker #(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic          cmd_ready_o,
  input logic [W-1:0]  cmd_dx_i,
  input logic [W-1:0]  cmd_dy_i,
  input logic          pix_valid_o,
  input logic          pix_ready_i,
  input logic [W-1:0]  pix_x_o,
  input logic [W-1:0]  pix_y_o,
  input logic [CW-1:0] pix_colour_o,
  input logic          busy_o,
  input logic [W-1:0]  org_x_o,
  input logic [W-1:0]  org_y_o
);
  logic acc_zero, acc_line;
  assign acc_zero = cmd_valid_i && cmd_ready_o && cmd_dx_i == '0 && cmd_dy_i == '0;
  assign acc_line = cmd_valid_i && cmd_ready_o && !(cmd_dx_i == '0 && cmd_dy_i == '0);

  assert_stall_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !pix_ready_i |=> pix_valid_o && $stable(pix_x_o) && $stable(pix_y_o)
                                    && $stable(pix_colour_o));

  assert_busy_after_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_line |=> busy_o && !cmd_ready_o);

  assert_zero_cmd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_zero |=> !busy_o && !pix_valid_o && $stable(org_x_o) && $stable(org_y_o));

  assert_org_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !(pix_valid_o && pix_ready_i) |=> $stable(org_x_o) && $stable(org_y_o));

  assert_valid_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> busy_o);

  assert_colour_fixed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(pix_colour_o));
endmodule

bind div_line_raster dlr_checker #(.W(W), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_ready_o  (cmd_ready_o),
  .cmd_dx_i     (cmd_dx_i),
  .cmd_dy_i     (cmd_dy_i),
  .pix_valid_o  (pix_valid_o),
  .pix_ready_i  (pix_ready_i),
  .pix_x_o      (pix_x_o),
  .pix_y_o      (pix_y_o),
  .pix_colour_o (pix_colour_o),
  .busy_o       (busy_o),
  .org_x_o      (org_x_o),
  .org_y_o      (org_y_o)
);

// File: tb/div_line_raster_test.sv
`timescale 1ns/1ps
module div_line_raster_test;
  localparam int W  = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cmd_valid_i = 1'b0;
  logic          cmd_ready_o;
  logic [CW-1:0] cmd_colour_i = '0;
  logic [W-1:0]  cmd_dx_i = '0;
  logic [W-1:0]  cmd_dy_i = '0;
  logic          pix_valid_o;
  logic          pix_ready_i = 1'b0;
  logic [W-1:0]  pix_x_o, pix_y_o;
  logic [CW-1:0] pix_colour_o;
  logic          busy_o;
  logic [W-1:0]  org_x_o, org_y_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int ox    = 0;
  int oy    = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  div_line_raster #(.W(W), .CW(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .cmd_colour_i(cmd_colour_i), .cmd_dx_i(cmd_dx_i), .cmd_dy_i(cmd_dy_i),
    .pix_valid_o(pix_valid_o), .pix_ready_i(pix_ready_i),
    .pix_x_o(pix_x_o), .pix_y_o(pix_y_o), .pix_colour_o(pix_colour_o),
    .busy_o(busy_o), .org_x_o(org_x_o), .org_y_o(org_y_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_line(input int dx, input int dy, input logic [CW-1:0] col,
                          input string tag);
    int adx, ady, maj, mnr, k, bx, by, ex, ey, mo, no, xe, ye;
    bit majx, opp, mneg, stalled;
    longint g;
    logic [W-1:0] hx, hy;
    adx  = dx < 0 ? -dx : dx;
    ady  = dy < 0 ? -dy : dy;
    majx = adx > ady;
    maj  = majx ? adx : ady;
    mnr  = majx ? ady : adx;
    opp  = (dx < 0) != (dy < 0);
    mneg = majx ? (dy < 0) : (dx < 0);
    g    = (maj == 0) ? 0 : ((mnr == maj) ? 65535 : (longint'(mnr) * 65536) / maj);
    ex   = (ox + dx) & 16'hFFFF;
    ey   = (oy + dy) & 16'hFFFF;
    bx   = mneg ? ex : ox;
    by   = mneg ? ey : oy;
    stalled = 1'b0;
    hx = '0;
    hy = '0;

    @(negedge clk);
    while (!cmd_ready_o) @(negedge clk);
    cmd_valid_i  = 1'b1;
    cmd_dx_i     = W'(dx);
    cmd_dy_i     = W'(dy);
    cmd_colour_i = col;
    @(negedge clk);
    cmd_valid_i = 1'b0;

    if (maj == 0) begin
      for (int c = 0; c < 4; c++) begin
        chk(!pix_valid_o && !busy_o, "R8", "no pixel, not busy", pix_valid_o, 0);
        @(negedge clk);
      end
      chk(org_x_o == W'(ox) && org_y_o == W'(oy), "R8", "origin unchanged",
          {org_y_o, org_x_o}, {oy[15:0], ox[15:0]});
      return;
    end

    chk(busy_o && !cmd_ready_o, "R9", "busy after accept",
        {busy_o, cmd_ready_o}, 2);

    k = 0;
    while (k < maj) begin
      if (stalled && pix_valid_o)
        chk(pix_x_o == hx && pix_y_o == hy, "R10", "held during stall",
            {pix_y_o, pix_x_o}, {hy, hx});
      stalled = 1'b0;
      if (pix_valid_o) begin
        if ((cyc % 3) == 1) begin
          pix_ready_i = 1'b0;
          stalled = 1'b1;
          hx = pix_x_o;
          hy = pix_y_o;
        end else begin
          pix_ready_i = 1'b1;
          mo = opp ? ((k ^ 16'hFFFF) & 16'hFFFF) : k;
          no = int'((g * k) >> 16);
          xe = (bx + (majx ? mo : no)) & 16'hFFFF;
          ye = (by + (majx ? no : mo)) & 16'hFFFF;
          chk(pix_x_o == W'(xe), majx ? "R4" : "R3", {tag, " pixel x"}, pix_x_o, xe);
          chk(pix_y_o == W'(ye), majx ? "R3" : "R4", {tag, " pixel y"}, pix_y_o, ye);
          chk(pix_colour_o == col, "R6", {tag, " colour"}, pix_colour_o, col);
          k++;
        end
      end else begin
        pix_ready_i = 1'b0;
      end
      @(negedge clk);
    end
    pix_ready_i = 1'b0;
    chk(!busy_o && !pix_valid_o && cmd_ready_o, "R6", {tag, " no extra pixel"},
        pix_valid_o, 0);
    chk(org_x_o == W'(ex) && org_y_o == W'(ey), "R7", {tag, " origin moved"},
        {org_y_o, org_x_o}, {ey[15:0], ex[15:0]});
    ox = ex;
    oy = ey;
  endtask

  initial begin
    #(5.0 * 190000);
    chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(org_x_o == 0 && org_y_o == 0, "R12", "reset origin", {org_y_o, org_x_o}, 0);
    chk(!busy_o && !pix_valid_o && cmd_ready_o, "R12", "reset idle",
        {busy_o, pix_valid_o, cmd_ready_o}, 1);

    // R1 sweep over every displacement in a small square
    for (int dy = -5; dy <= 5; dy++)
      for (int dx = -5; dx <= 5; dx++)
        run_line(dx, dy, CW'(dx * 16 + dy), "R1");

    // R2 saturated gradient, equal magnitudes in all quadrants
    run_line(6, 6, 8'h11, "R2");
    run_line(-6, 6, 8'h12, "R2");
    run_line(6, -6, 8'h13, "R2");
    run_line(-6, -6, 8'h14, "R2");
    run_line(300, 7, 8'h15, "R2");
    // R5 negative minor axis, shifted base
    run_line(37, -11, 8'h21, "R5");
    run_line(-9, 40, 8'h22, "R5");
    // R8 zero command between lines
    run_line(0, 0, 8'h31, "R8");
    // R11 wrap across the coordinate boundary
    run_line(-32768, 5, 8'h41, "R11");
    run_line(200, -32767, 8'h42, "R11");
    run_line(0, 0, 8'h43, "R8");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule